// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block produces the fetch address for a 32-bit processor whose branches have one delay slot. It keeps three address registers: the address being fetched now, the address that follows it, and the address of the instruction that was stepped before it. Because the following address is already committed when a branch resolves, the instruction after a taken branch still runs. The branch target becomes the following address only once that instruction has become the current one.

Each pulse of the step strobe moves the sequence on by one. A breakpoint match on the current fetch address holds the sequence for one attempt. A second attempt at the same address always proceeds, because a one-bit armed flag blocks an immediate second trigger. A pending exception still advances the addresses, but the instruction does not execute: any branch it signals is ignored and it is not counted as retired. At reset the start address is built from a base that an exception-prefix control bit selects, plus a reset vector offset.

Top module: `delay_slot_pc_seq`

## Requirements
- R1: While rstN is low at a clock edge, the block loads base = 0xF0000000 if prefixHigh is 1, else base = 0x00000000. It sets fetchAddr = base + RST_OFFSET (default 0x100), nextAddr = fetchAddr + 4, prevAddr = base, inDelaySlot = 0 and retiredCnt = 0. prefixHigh has no effect outside reset.
- R2: A step that proceeds with no branch redirect moves fetchAddr into prevAddr and nextAddr into fetchAddr. It sets nextAddr to the new fetchAddr + 4 and clears inDelaySlot.
- R3: A step that proceeds with brTaken = 1 and excPending = 0 moves the addresses as in R2. It then loads nextAddr with the brTarget of that cycle and sets inDelaySlot to 1. The next step clears inDelaySlot unless it also branches.
- R4: In a cycle with stepEn = 0, fetchAddr, nextAddr, prevAddr, inDelaySlot and retiredCnt all hold their values.
- R5: A step with bkptHit = 1 while the armed flag is clear is suppressed. bkptStop = 1 and execOk = 0 in that cycle. The addresses, inDelaySlot and retiredCnt hold, and the armed flag is set.
- R6: A step taken while the armed flag is set proceeds even if bkptHit = 1. Any step that proceeds clears the flag, so a later match fires again.
- R7: A step that proceeds with excPending = 1 advances the addresses as in R2, with execOk = 0. brTaken is ignored, and retiredCnt does not change.
- R8: retiredCnt increases by one for each step that proceeds with excPending = 0 and wraps modulo 2^CNT_W. It changes in no other cycle.
- R9: execOk = stepEn & !bkptStop & !excPending and bkptStop = stepEn & bkptHit & !armed, both combinational in the same cycle. A breakpoint takes precedence over a pending exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| prefixHigh | input | 1 | Selects the high reset base while in reset |
| stepEn | input | 1 | Step strobe, one sequence advance per cycle |
| brTaken | input | 1 | Instruction at fetchAddr is a taken branch |
| brTarget | input | ADDR_W | Branch destination, used in the cycle brTaken is high |
| excPending | input | 1 | Exception pending for this step |
| bkptHit | input | 1 | Breakpoint matches fetchAddr |
| fetchAddr | output | ADDR_W | Current fetch address |
| nextAddr | output | ADDR_W | Address that follows the current one |
| prevAddr | output | ADDR_W | Address stepped before the current one |
| inDelaySlot | output | 1 | Current instruction sits in a branch delay slot |
| execOk | output | 1 | This step executes the instruction |
| bkptStop | output | 1 | This step is suppressed by a breakpoint |
| retiredCnt | output | CNT_W | Retired instruction count |

## Verification
The bench runs every ordered pair of the sixteen control-input combinations, once for each value of the prefix bit. This covers a branch placed in a delay slot, an exception in the same cycle as a branch, and a breakpoint held high over consecutive steps. A design that used the target one step early would skip the delay slot, and a wrong nextAddr shows it. A design that let an exception redirect would show a wrong target, and one that re-armed the breakpoint on every match would stall for good. The bench also changes prefixHigh after reset, so a design that reads the prefix bit outside reset moves its addresses. It retires more than 2^CNT_W instructions, so a counter that fails to wrap is caught.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic advance;   // shift the address pipeline
    logic redirect;  // next address comes from the branch target
    logic retire;    // count one retired instruction
  } seqCtl_t;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    stepEn,
  input  logic    brTaken,
  input  logic    excPending,
  input  logic    bkptHit,
  output seqCtl_t ctl,
  output logic    execOk,
  output logic    bkptStop
);
  logic armed;
  logic proceed;

  // Breakpoint is checked at fetch, before the exception path
  assign bkptStop = stepEn & bkptHit & ~armed;
  assign proceed  = stepEn & ~bkptStop;
  assign execOk   = proceed & ~excPending;

  always_comb begin
    ctl          = '0;
    ctl.advance  = proceed;
    ctl.redirect = proceed & ~excPending & brTaken;
    ctl.retire   = proceed & ~excPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          armed <= 1'b0;
    else if (bkptStop)  armed <= 1'b1;
    else if (proceed)   armed <= 1'b0;
  end

  AST_BKPT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    bkptStop |=> !bkptStop);                                   // R6
  AST_STOP_NO_ADV: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.advance, bkptStop}));                        // R5
  AST_EXC_NO_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    excPending |-> !execOk && !ctl.redirect);                  // R7
  AST_RETIRE_ADV: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retire |-> ctl.advance);                               // R8
endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RST_OFFSET = 'h100,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hF000_0000,
  parameter int                CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prefixHigh,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] brTarget,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] prevAddr,
  output logic              inDelaySlot,
  output logic [CNT_W-1:0]  retiredCnt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] rstBase;
  logic [ADDR_W-1:0] rstPc;
  logic [ADDR_W-1:0] seqNext;

  assign rstBase = prefixHigh ? HIGH_BASE : '0;
  assign rstPc   = rstBase + RST_OFFSET;
  assign seqNext = nextAddr + STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr   <= rstPc;
      nextAddr    <= rstPc + STEP;
      prevAddr    <= rstBase;
      inDelaySlot <= 1'b0;
    end else if (ctl.advance) begin
      prevAddr    <= fetchAddr;
      fetchAddr   <= nextAddr;
      nextAddr    <= ctl.redirect ? brTarget : seqNext;
      inDelaySlot <= ctl.redirect;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           retiredCnt <= '0;
    else if (ctl.retire) retiredCnt <= retiredCnt + 1'b1;
  end

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> prevAddr == $past(fetchAddr));             // R2
  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance && !ctl.redirect |=> nextAddr == fetchAddr + STEP && !inDelaySlot); // R2
  AST_BR_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance && ctl.redirect |=> nextAddr == $past(brTarget) && inDelaySlot);    // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.advance |=> $stable(fetchAddr) && $stable(nextAddr) && $stable(prevAddr)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.retire |=> $stable(retiredCnt));                      // R8
endmodule

// File: rtl/delay_slot_pc_seq.sv
module delay_slot_pc_seq
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RST_OFFSET = 'h100,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hF000_0000,
  parameter int                CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prefixHigh,
  input  logic              stepEn,
  input  logic              brTaken,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              excPending,
  input  logic              bkptHit,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] prevAddr,
  output logic              inDelaySlot,
  output logic              execOk,
  output logic              bkptStop,
  output logic [CNT_W-1:0]  retiredCnt
);
  seqCtl_t ctl;

  pcseq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .brTaken    (brTaken),
    .excPending (excPending),
    .bkptHit    (bkptHit),
    .ctl        (ctl),
    .execOk     (execOk),
    .bkptStop   (bkptStop)
  );

  pcseq_datapath #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES),
    .RST_OFFSET (RST_OFFSET),
    .HIGH_BASE  (HIGH_BASE),
    .CNT_W      (CNT_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .prefixHigh  (prefixHigh),
    .ctl         (ctl),
    .brTarget    (brTarget),
    .fetchAddr   (fetchAddr),
    .nextAddr    (nextAddr),
    .prevAddr    (prevAddr),
    .inDelaySlot (inDelaySlot),
    .retiredCnt  (retiredCnt)
  );
endmodule

// File: tb/test_delay_slot_pc_seq.sv
module test_delay_slot_pc_seq;
  localparam int          AW  = 32;
  localparam int          CW  = 4;
  localparam logic [31:0] OFF = 32'h100;
  localparam logic [31:0] HB  = 32'hF000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0, prefixHigh = 1'b0, stepEn = 1'b0, brTaken = 1'b0;
  logic excPending = 1'b0, bkptHit = 1'b0;
  logic [AW-1:0] brTarget = '0;
  logic [AW-1:0] fetchAddr, nextAddr, prevAddr;
  logic inDelaySlot, execOk, bkptStop;
  logic [CW-1:0] retiredCnt;

  delay_slot_pc_seq #(.ADDR_W(AW), .INSN_BYTES(4), .RST_OFFSET(OFF),
                      .HIGH_BASE(HB), .CNT_W(CW)) i_delay_slot_pc_seq (
    .clk(clk), .rstN(rstN), .prefixHigh(prefixHigh), .stepEn(stepEn),
    .brTaken(brTaken), .brTarget(brTarget), .excPending(excPending),
    .bkptHit(bkptHit), .fetchAddr(fetchAddr), .nextAddr(nextAddr),
    .prevAddr(prevAddr), .inDelaySlot(inDelaySlot), .execOk(execOk),
    .bkptStop(bkptStop), .retiredCnt(retiredCnt));

  always #4 clk = ~clk;  // 125 MHz

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  logic [31:0] mPc, mNext, mPrev;
  logic        mDs, mArmed;
  logic [CW-1:0] mCnt;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    chk(tag, "fetchAddr", fetchAddr, mPc);
    chk(tag, "nextAddr", nextAddr, mNext);
    chk(tag, "prevAddr", prevAddr, mPrev);
    chk(tag, "inDelaySlot", {31'b0, inDelaySlot}, {31'b0, mDs});
  endtask

  task automatic doReset(input logic ph);
    logic [31:0] base;
    @(negedge clk);
    rstN = 1'b0; prefixHigh = ph; stepEn = 1'b0;
    brTaken = 1'b0; excPending = 1'b0; bkptHit = 1'b0;
    @(posedge clk); #1;
    base  = ph ? HB : 32'h0;
    mPc   = base + OFF; mNext = base + OFF + 32'd4; mPrev = base;
    mDs   = 1'b0; mArmed = 1'b0; mCnt = '0;
    chkRegs("R1");
    chk("R1", "retiredCnt", {28'b0, retiredCnt}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    prefixHigh = ~ph;  // R1: must not matter outside reset
  endtask

  task automatic doStep(input logic [3:0] pat, input logic [31:0] tgt);
    logic stop, ok, take, proceed;
    string tag;
    @(negedge clk);
    {stepEn, brTaken, excPending, bkptHit} = pat;
    brTarget = tgt;
    #1;
    stop    = stepEn & bkptHit & ~mArmed;
    proceed = stepEn & ~stop;
    ok      = proceed & ~excPending;
    take    = ok & brTaken;
    chk("R9", "execOk", {31'b0, execOk}, {31'b0, ok});
    chk("R9", "bkptStop", {31'b0, bkptStop}, {31'b0, stop});
    if (!stepEn)                           tag = "R4";
    else if (stop)                         tag = "R5";
    else if (bkptHit && mArmed)            tag = "R6";
    else if (excPending)                   tag = "R7";
    else if (take)                         tag = "R3";
    else                                   tag = "R2";
    @(posedge clk); #1;
    if (stop) mArmed = 1'b1;
    else if (proceed) begin
      mArmed = 1'b0;
      if (ok) mCnt = mCnt + 1'b1;
      mPrev = mPc;
      mPc   = mNext;
      mNext = take ? tgt : mNext + 32'd4;
      mDs   = take;
    end
    chkRegs(tag);
    chk(ok ? "R8" : tag, "retiredCnt", {28'b0, retiredCnt}, {28'b0, mCnt});
  endtask

  initial begin
    for (int ph = 0; ph < 2; ph++) begin
      doReset(ph[0]);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          doStep(a[3:0], 32'h0000_2000 + {a[15:0], b[7:0], 4'h0} + (ph << 28));
          doStep(b[3:0], 32'h0004_0000 + {b[15:0], a[7:0], 4'h8});
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule